// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small store of upcoming instruction bytes ahead of an instruction decoder. On its memory side it issues word-wide fetch requests at sequential code addresses, one outstanding at a time, and each completed fetch writes up to two bytes into a six-entry circular store. On its decoder side it presents the oldest byte with a valid/ready pair and releases one byte per accepted handshake.

A fetch is only started when the store has room for a whole word and the execution side is not asking for the bus for an operand transfer. If neither applies, the memory interface stays idle with no request raised. A flush input, used on control transfers, empties the store in one cycle, discards a fetch that completes in that same cycle and redirects fetching to a new byte address. An odd redirect address is handled by fetching the enclosing aligned word and keeping only its upper byte.

Top module: `instr_prefetch_queue`

## Requirements
- R1: The store never holds more than DEPTH (default 6) bytes, and `byte_valid_o` is high exactly when it holds at least one byte.
- R2: A fetch completed (`fetch_ack_i` high while `fetch_req_o` is high and `flush_i` is low) at an even byte address appends `fetch_data_i[7:0]` and then `fetch_data_i[15:8]`, the low half being the byte at the even address.
- R3: Bytes leave in arrival order; `byte_data_o` shows the oldest byte and one byte is removed on each cycle with `byte_valid_o` and `byte_ready_i` both high; while not accepted, the byte stays stable.
- R4: A new request is raised in the cycle after an idle cycle in which the store held at most DEPTH-2 bytes, `opnd_req_i` was low and `flush_i` was low; in every other idle cycle `fetch_req_o` stays low.
- R5: Once raised, `fetch_req_o` and `fetch_addr_o` stay unchanged until the cycle of `fetch_ack_i` or `flush_i`, after which the request is low for at least one cycle.
- R6: `fetch_addr_o` is always an even byte address; after a completed fetch the next request uses the aligned address plus 2.
- R7: With `flush_i` high, the next cycle shows an empty store (`byte_valid_o` low), no request, and any fetch completing in the flush cycle leaves no bytes behind; fetching resumes from `flush_addr_i`.
- R8: When the fetch pointer is odd, the request goes to the pointer minus 1, only `fetch_data_i[15:8]` is appended, and the next request goes to the pointer plus 1.
- R9: When `opnd_req_i` is high in a cycle that would otherwise start a fetch, no request is raised in the next cycle.
- R10: After reset the request and `byte_valid_o` are low and the fetch pointer equals RESET_ADDR (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Empty the store and redirect fetching |
| flush_addr_i | input | AW (16) | New byte address for fetching after a flush |
| opnd_req_i | input | 1 | Execution side needs the bus for an operand transfer |
| fetch_req_o | output | 1 | Word fetch request |
| fetch_addr_o | output | AW (16) | Even byte address of the requested word |
| fetch_ack_i | input | 1 | Fetch completes this cycle, data valid |
| fetch_data_i | input | 16 | Fetched word, low byte at the even address |
| byte_valid_o | output | 1 | A byte is available to the decoder |
| byte_data_o | output | 8 | Oldest stored byte |
| byte_ready_i | input | 1 | Decoder takes the byte this cycle |

## Verification
Two pairs of functions can coincide: a flush can land in the cycle a fetch completes (and a byte is taken), and an operand request can land in the cycle a prefetch would otherwise start. Both are provoked by a directed flush to an odd address with an acknowledge in the same cycle, by holding the operand request over cycles with free space, and by random stimulus that overlaps flush, acknowledge, ready and operand request. A reference byte queue and fetch pointer kept in the bench judge them, predicting the request line, the requested address, the valid flag and every delivered byte cycle by cycle.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_BUSY = 1'b1
  } fetch_state_e;
endpackage

// File: rtl/pfq_rst_sync.sv
module pfq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl
  import pfq_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DEPTH      = 6,
  parameter int RESET_ADDR = 0,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          flush_i,
  input  logic [AW-1:0] flush_addr_i,
  input  logic          opnd_req_i,
  input  logic          fetch_ack_i,
  input  logic [CW-1:0] q_count_i,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  output logic          wr_lo_en_o,
  output logic          wr_hi_en_o
);
  fetch_state_e  state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_en;
  logic          ack_take;
  logic          room_ok;
  logic [AW-1:0] aligned;

  assign aligned  = {ptr_q[AW-1:1], 1'b0};
  assign room_ok  = (q_count_i <= CW'(DEPTH - 2));
  assign ack_take = (state_q == FS_BUSY) && fetch_ack_i && !flush_i;

  always_comb begin
    state_d = state_q;
    ptr_en  = 1'b0;
    ptr_d   = ptr_q;
    if (flush_i) begin
      state_d = FS_IDLE;
      ptr_en  = 1'b1;
      ptr_d   = flush_addr_i;
    end else begin
      case (state_q)
        FS_IDLE: if (!opnd_req_i && room_ok) state_d = FS_BUSY;
        FS_BUSY: if (fetch_ack_i) begin
          state_d = FS_IDLE;
          ptr_en  = 1'b1;
          ptr_d   = aligned + AW'(2);
        end
        default: state_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= FS_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     ptr_q <= AW'(RESET_ADDR);
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign fetch_req_o  = (state_q == FS_BUSY);
  assign fetch_addr_o = aligned;
  assign wr_lo_en_o   = ack_take && !ptr_q[0];
  assign wr_hi_en_o   = ack_take;

  // R9
  opnd_blocks_start_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!fetch_req_o && opnd_req_i) |=> !fetch_req_o);

  // R4
  no_start_when_tight_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!fetch_req_o && (q_count_i > CW'(DEPTH - 2))) |=> !fetch_req_o);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (fetch_req_o && !fetch_ack_i && !flush_i) |=> (fetch_req_o && $stable(fetch_addr_o)));

  // R5
  idle_after_ack_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (fetch_req_o && (fetch_ack_i || flush_i)) |=> !fetch_req_o);

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (fetch_req_o && fetch_ack_i && !flush_i) |=> (fetch_addr_o == $past(fetch_addr_o) + AW'(2)));
endmodule

// File: rtl/pfq_store.sv
module pfq_store #(
  parameter int DEPTH = 6,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          flush_i,
  input  logic          wr_lo_en_i,
  input  logic          wr_hi_en_i,
  input  logic [15:0]   wr_data_i,
  input  logic          rd_ready_i,
  output logic [CW-1:0] count_o,
  output logic          rd_valid_o,
  output logic [7:0]    rd_data_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] ent_we;
  logic [7:0]    ent_wd [DEPTH];
  logic [PW-1:0] head_q, head_d, tail_q, tail_d, tail_p1;
  logic [CW-1:0] count_q, count_d;
  logic          pop;
  logic [1:0]    n_wr;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign tail_p1 = ptr_inc(tail_q);
  assign pop     = rd_ready_i && (count_q != '0);
  assign n_wr    = {1'b0, wr_lo_en_i} + {1'b0, wr_hi_en_i};

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ent_we[i] = 1'b0;
      ent_wd[i] = wr_data_i[7:0];
      if (wr_hi_en_i) begin
        if (wr_lo_en_i) begin
          if (tail_q == PW'(i))  ent_we[i] = 1'b1;
          if (tail_p1 == PW'(i)) begin
            ent_we[i] = 1'b1;
            ent_wd[i] = wr_data_i[15:8];
          end
        end else if (tail_q == PW'(i)) begin
          ent_we[i] = 1'b1;
          ent_wd[i] = wr_data_i[15:8];
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (ent_we[g]) mem_q[g] <= ent_wd[g];
      end
    end
  endgenerate

  always_comb begin
    head_d  = head_q;
    tail_d  = tail_q;
    count_d = count_q;
    if (flush_i) begin
      head_d  = '0;
      tail_d  = '0;
      count_d = '0;
    end else begin
      if (pop) head_d = ptr_inc(head_q);
      if (wr_lo_en_i && wr_hi_en_i) tail_d = ptr_inc(tail_p1);
      else if (wr_hi_en_i)          tail_d = tail_p1;
      count_d = count_q + CW'(n_wr) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  assign count_o    = count_q;
  assign rd_valid_o = (count_q != '0);
  assign rd_data_o  = mem_q[head_q];

  // R1
  count_le_depth_chk: assert property (@(posedge clk) disable iff (!srst_n)
    count_q <= CW'(DEPTH));

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!srst_n)
    flush_i |=> !rd_valid_o);

  // R3
  pop_takes_one_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (pop && !wr_hi_en_i && !flush_i) |=> (count_q == $past(count_q) - CW'(1)));
endmodule

// File: rtl/instr_prefetch_queue.sv
module instr_prefetch_queue #(
  parameter int AW         = 16,
  parameter int DEPTH      = 6,
  parameter int RESET_ADDR = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [AW-1:0] flush_addr_i,
  input  logic          opnd_req_i,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  input  logic          fetch_ack_i,
  input  logic [15:0]   fetch_data_i,
  output logic          byte_valid_o,
  output logic [7:0]    byte_data_o,
  input  logic          byte_ready_i
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          srst_n;
  logic [CW-1:0] q_count;
  logic          wr_lo_en, wr_hi_en;

  pfq_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  pfq_fetch_ctrl #(
    .AW         (AW),
    .DEPTH      (DEPTH),
    .RESET_ADDR (RESET_ADDR)
  ) u_fetch_ctrl (
    .clk          (clk),
    .srst_n       (srst_n),
    .flush_i      (flush_i),
    .flush_addr_i (flush_addr_i),
    .opnd_req_i   (opnd_req_i),
    .fetch_ack_i  (fetch_ack_i),
    .q_count_i    (q_count),
    .fetch_req_o  (fetch_req_o),
    .fetch_addr_o (fetch_addr_o),
    .wr_lo_en_o   (wr_lo_en),
    .wr_hi_en_o   (wr_hi_en)
  );

  pfq_store #(
    .DEPTH (DEPTH)
  ) u_store (
    .clk        (clk),
    .srst_n     (srst_n),
    .flush_i    (flush_i),
    .wr_lo_en_i (wr_lo_en),
    .wr_hi_en_i (wr_hi_en),
    .wr_data_i  (fetch_data_i),
    .rd_ready_i (byte_ready_i),
    .count_o    (q_count),
    .rd_valid_o (byte_valid_o),
    .rd_data_o  (byte_data_o)
  );

  // R3
  byte_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (byte_valid_o && !byte_ready_i && !flush_i) |=> (byte_valid_o && $stable(byte_data_o)));
endmodule

// File: tb/instr_prefetch_queue_bench.sv
`timescale 1ns/1ps
module instr_prefetch_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i;
  logic [15:0] flush_addr_i;
  logic        opnd_req_i;
  logic        fetch_req_o;
  logic [15:0] fetch_addr_o;
  logic        fetch_ack_i;
  logic [15:0] fetch_data_i;
  logic        byte_valid_o;
  logic [7:0]  byte_data_o;
  logic        byte_ready_i;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0]  mq[$];
  logic [15:0] exp_ptr;
  bit prev_req, prev_ack, prev_flush, prev_ok;

  always #2.5 clk = ~clk;

  instr_prefetch_queue u_instr_prefetch_queue (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .opnd_req_i(opnd_req_i), .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
    .fetch_ack_i(fetch_ack_i), .fetch_data_i(fetch_data_i), .byte_valid_o(byte_valid_o),
    .byte_data_o(byte_data_o), .byte_ready_i(byte_ready_i)
  );

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge: compare, then drive inputs for the next rising edge.
  task automatic step(input bit fl, input logic [15:0] fa, input bit op, input bit rd, input bit ak);
    bit exp_req, ack;
    logic [15:0] al;
    exp_req = prev_req ? !(prev_ack || prev_flush) : prev_ok;
    chk(fetch_req_o == exp_req, "R4 R5 R9 request", int'(fetch_req_o), int'(exp_req));
    al = {exp_ptr[15:1], 1'b0};
    if (fetch_req_o)
      chk(fetch_addr_o == al, "R5 R6 R8 address", int'(fetch_addr_o), int'(al));
    chk(byte_valid_o == (mq.size() != 0), "R1 valid", int'(byte_valid_o), int'(mq.size() != 0));
    chk(mq.size() <= 6, "R1 depth", mq.size(), 6);
    if (byte_valid_o && mq.size() != 0)
      chk(byte_data_o == mq[0], "R2 R3 R8 data", int'(byte_data_o), int'(mq[0]));
    ack = ak && fetch_req_o;
    flush_i      = fl;
    flush_addr_i = fa;
    opnd_req_i   = op;
    byte_ready_i = rd;
    fetch_ack_i  = ack;
    fetch_data_i = ack ? {mbyte(al + 16'd1), mbyte(al)} : 16'($urandom);
    prev_ok    = !fetch_req_o && (mq.size() <= 4) && !op && !fl;
    prev_req   = fetch_req_o;
    prev_ack   = ack;
    prev_flush = fl;
    if (rd && mq.size() != 0) void'(mq.pop_front());
    if (fl) begin
      mq.delete();
      exp_ptr = fa;
    end else if (ack) begin
      if (exp_ptr[0]) begin
        mq.push_back(mbyte(exp_ptr));
        exp_ptr = exp_ptr + 16'd1;
      end else begin
        mq.push_back(mbyte(exp_ptr));
        mq.push_back(mbyte(exp_ptr + 16'd1));
        exp_ptr = exp_ptr + 16'd2;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; flush_i = 0; flush_addr_i = 0; opnd_req_i = 1'b1;
    fetch_ack_i = 0; fetch_data_i = 0; byte_ready_i = 0;
    exp_ptr = 16'h0000;
    repeat (3) @(negedge clk);
    chk(!fetch_req_o, "R10 reset request", int'(fetch_req_o), 0);
    chk(!byte_valid_o, "R10 reset valid", int'(byte_valid_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!fetch_req_o, "R9 no request while operand busy", int'(fetch_req_o), 0);
    prev_req = 0; prev_ack = 0; prev_flush = 0; prev_ok = 0;

    // Fill with no reads: stops at six bytes (R1, R4), starting at RESET_ADDR (R10)
    for (int i = 0; i < 20; i++) step(0, 16'h0, 0, 0, 1);
    chk(mq.size() == 6, "R1 full model", mq.size(), 6);
    chk(byte_valid_o && !fetch_req_o, "R1 R4 full idle", int'(fetch_req_o), 0);
    // Drain three, request raised and held without ack (R5)
    for (int i = 0; i < 3; i++) step(0, 16'h0, 0, 1, 0);
    for (int i = 0; i < 3; i++) step(0, 16'h0, 0, 0, 0);
    // Flush to odd address with ack in the same cycle (R7, R8)
    step(1, 16'h0103, 0, 1, 1);
    chk(!byte_valid_o, "R7 empty after flush", int'(byte_valid_o), 0);
    chk(!fetch_req_o, "R7 no request after flush", int'(fetch_req_o), 0);
    for (int i = 0; i < 12; i++) step(0, 16'h0, 0, 1, 1);
    // Operand requests hold off prefetch (R9)
    for (int i = 0; i < 8; i++) step(0, 16'h0, 1, 1, 1);
    chk(!fetch_req_o, "R9 operand wins", int'(fetch_req_o), 0);

    for (int i = 0; i < 4000; i++)
      step(($urandom % 40) == 0, 16'($urandom), ($urandom % 5) == 0,
           ($urandom % 3) != 0, ($urandom % 2) == 0);
    for (int i = 0; i < 20; i++) step(0, 16'h0, 0, 1, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule